// File: doc/BRIEF.md
# Sparse Weight Stream Decompressor

This block turns a zero-skipped convolution weight stream back into a dense one. Three input streams feed it. A mask stream carries one presence bit per weight element. A packed stream carries only the bytes of non-zero elements. A count stream gives, for each kernel group, how many packed bytes that group should consume. For each element position the block reads the next mask bit. A set bit takes the element from the packed bytes, and a clear bit emits a zero without touching the packed stream.

Element width is selected per layer. In 16-bit mode (int16 or fp16) an element is two packed bytes. In int8 mode an element is one byte, sign-extended onto the 16-bit output. The group length in elements is a configuration input. The final element of every group carries a last flag. When a group closes, the bytes it actually consumed are compared with its supplied count, and any difference raises an error flag that stays set until reset.

Top module: `sparse_weight_decomp`

## Requirements
- R1: While reset is held and on the cycle after it is released, `out_valid` is 0, `err_count` is 0, `mask_ready` and `pk_ready` are 1 and `gcnt_ready` is 0.
- R2: Mask bits are used least significant bit first. Bit 0 of the first mask byte after reset belongs to the first element. A 0 bit produces an output element of 0 and consumes no packed byte.
- R3: With `cfg_elem16` = 1, a mask bit of 1 consumes two packed bytes. The first byte becomes `out_data[7:0]` and the second becomes `out_data[15:8]`.
- R4: With `cfg_elem16` = 0, a mask bit of 1 consumes one packed byte. It is placed in `out_data[7:0]`, and `out_data[15:8]` copies its bit 7.
- R5: Every group has exactly `cfg_group_elems` elements (at least 1, held constant while a stream runs). `out_last` is 1 on the final element of each group and 0 on every other element.
- R6: The final element of a group is offered only while `gcnt_valid` is 1. `gcnt_ready` is 1 exactly in the cycle that element is accepted.
- R7: When a group closes and the bytes it consumed differ from `gcnt_data`, `err_count` becomes 1 from the next cycle and stays 1 until reset. When they match, `err_count` is left unchanged.
- R8: Mask bits run on across group boundaries without realignment. A group may start in the middle of a mask byte.
- R9: While `out_valid` is 1 and `out_ready` is 0 on a non-final element, the offered element stays valid and unchanged in the next cycle. With all inputs kept valid and `out_ready` high, one element is accepted every cycle in either width.
- R10: In each packed beat, `pk_data[7:0]` is the earlier byte and `pk_data[15:8]` the later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_elem16 | input | 1 | 1: two-byte elements, 0: one-byte elements |
| cfg_group_elems | input | 16 | Elements per kernel group |
| mask_valid | input | 1 | Mask byte offered |
| mask_data | input | 8 | Mask byte, one bit per element |
| mask_ready | output | 1 | Mask byte accepted |
| pk_valid | input | 1 | Packed beat offered |
| pk_data | input | 16 | Two packed non-zero weight bytes |
| pk_ready | output | 1 | Packed beat accepted |
| gcnt_valid | input | 1 | Group byte count offered |
| gcnt_data | input | 32 | Packed bytes expected for the current group |
| gcnt_ready | output | 1 | Group byte count consumed |
| out_valid | output | 1 | Dense element offered |
| out_data | output | 16 | Dense element |
| out_last | output | 1 | Final element of a group |
| out_ready | input | 1 | Downstream accepts the element |
| err_count | output | 1 | Sticky byte-count mismatch flag |

## Verification
Wrong internal state shows up at the ports within a group or two. If the mask bit pointer is off by one, zeros land in the wrong positions on the next element. If the byte buffer pops the wrong amount, every later non-zero value shifts or mixes bytes, and the miscount is also flagged as a count error at the following group end. If the element counter slips, `out_last` moves off the expected positions and the count handshake happens in the wrong cycle. Stalls are compared cycle by cycle, so a pointer that advances during back-pressure is caught on the very next element.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int BYTE_W = 8;
    localparam int ELEM_W = 2 * BYTE_W;

    typedef enum logic {
        MODE_B1 = 1'b0,
        MODE_B2 = 1'b1
    } elem_mode_e;

    typedef struct packed {
        logic [ELEM_W-1:0] data;
        logic              last;
    } dense_elem_t;

    function automatic logic [1:0] bytes_per_elem(elem_mode_e m);
        return (m == MODE_B2) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [ELEM_W-1:0] form_elem(elem_mode_e m,
                                                    logic [BYTE_W-1:0] lo,
                                                    logic [BYTE_W-1:0] hi);
        if (m == MODE_B2)
            return {hi, lo};
        return {{BYTE_W{lo[BYTE_W-1]}}, lo};
    endfunction

endpackage

// File: rtl/swd_mask_feed.sv
module swd_mask_feed #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_valid,
    input  logic [MASK_W-1:0] mask_data,
    output logic              mask_ready,
    input  logic              take,
    output logic              bit_valid,
    output logic              bit_val
);
    localparam int LEFT_W = $clog2(MASK_W + 1);

    logic [MASK_W-1:0] bits_q;
    logic [LEFT_W-1:0] left_q;

    assign bit_valid  = (left_q != '0);
    assign bit_val    = bits_q[0];
    assign mask_ready = (left_q == '0) || ((left_q == LEFT_W'(1)) && take);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            left_q <= '0;
        end else if (mask_valid && mask_ready) begin
            bits_q <= mask_data;
            left_q <= LEFT_W'(MASK_W);
        end else if (take) begin
            bits_q <= bits_q >> 1;
            left_q <= left_q - LEFT_W'(1);
        end
    end

    // R2: a bit is only consumed when one is held
    p_take_has_bit_r2: assert property (@(posedge clk) disable iff (rst)
        take |-> bit_valid);

    // R8: bit count never exceeds one mask byte
    p_left_bound_r8: assert property (@(posedge clk) disable iff (rst)
        left_q <= LEFT_W'(MASK_W));

endmodule

// File: rtl/swd_byte_align.sv
module swd_byte_align #(
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [8*LANES-1:0]     in_data,
    output logic                   in_ready,
    input  logic [$clog2(LANES+1)-1:0] pop,
    output logic [7:0]             head0,
    output logic [7:0]             head1,
    output logic [$clog2(2*LANES+1)-1:0] level
);
    localparam int DEPTH = 2 * LANES;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [7:0]       q_q [DEPTH];
    logic [7:0]       q_n [DEPTH];
    logic [LVL_W-1:0] lvl_q;
    logic             acc;

    assign in_ready = (lvl_q <= LVL_W'(DEPTH - LANES));
    assign acc      = in_valid && in_ready;
    assign head0    = q_q[0];
    assign head1    = q_q[1];
    assign level    = lvl_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_n[i] = '0;
            if ((i + int'(pop)) < int'(lvl_q))
                q_n[i] = q_q[i + int'(pop)];
            else if (acc && ((i + int'(pop) - int'(lvl_q)) < LANES))
                q_n[i] = in_data[8*(i + int'(pop) - int'(lvl_q)) +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
        end else begin
            lvl_q <= lvl_q - LVL_W'(pop) + (acc ? LVL_W'(LANES) : LVL_W'(0));
            for (int i = 0; i < DEPTH; i++) q_q[i] <= q_n[i];
        end
    end

    // R3: never pop more bytes than are held
    p_pop_le_level_r3: assert property (@(posedge clk) disable iff (rst)
        LVL_W'(pop) <= lvl_q);

    // R10: occupancy stays within the buffer
    p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_W'(DEPTH));

endmodule

// File: rtl/swd_group_track.sv
module swd_group_track #(
    parameter int CNT_ELEM_W = 16,
    parameter int CNT_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic [1:0]            bytes_used,
    input  logic [CNT_ELEM_W-1:0] group_elems,
    input  logic [CNT_W-1:0]      cnt_data,
    output logic                  is_last,
    output logic                  err
);
    logic [CNT_ELEM_W-1:0] idx_q;
    logic [CNT_W-1:0]      acc_q;
    logic [CNT_W-1:0]      acc_n;
    logic                  err_q;

    assign is_last = (idx_q == group_elems - CNT_ELEM_W'(1));
    assign acc_n   = acc_q + CNT_W'(bytes_used);
    assign err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            acc_q <= '0;
            err_q <= 1'b0;
        end else if (fire) begin
            if (is_last) begin
                idx_q <= '0;
                acc_q <= '0;
                if (acc_n != cnt_data) err_q <= 1'b1;
            end else begin
                idx_q <= idx_q + CNT_ELEM_W'(1);
                acc_q <= acc_n;
            end
        end
    end

    // R7: the error flag never clears outside reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R5: closing a group restarts the element position
    p_group_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && is_last) |=> (idx_q == '0) && (acc_q == '0));

endmodule

// File: rtl/sparse_weight_decomp.sv
module sparse_weight_decomp
    import swd_pkg::*;
#(
    parameter int CNT_ELEM_W = 16,
    parameter int CNT_W      = 32,
    parameter int LANES      = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_elem16,
    input  logic [CNT_ELEM_W-1:0] cfg_group_elems,
    input  logic                  mask_valid,
    input  logic [BYTE_W-1:0]     mask_data,
    output logic                  mask_ready,
    input  logic                  pk_valid,
    input  logic [8*LANES-1:0]    pk_data,
    output logic                  pk_ready,
    input  logic                  gcnt_valid,
    input  logic [CNT_W-1:0]      gcnt_data,
    output logic                  gcnt_ready,
    output logic                  out_valid,
    output logic [ELEM_W-1:0]     out_data,
    output logic                  out_last,
    input  logic                  out_ready,
    output logic                  err_count
);
    localparam int POP_W = $clog2(LANES + 1);
    localparam int LVL_W = $clog2(2 * LANES + 1);

    elem_mode_e       mode;
    logic [1:0]       need;
    logic             bit_valid, bit_val;
    logic             have, fire, is_last;
    logic [POP_W-1:0] pop;
    logic [7:0]       head0, head1;
    logic [LVL_W-1:0] level;
    dense_elem_t      elem;

    assign mode = elem_mode_e'(cfg_elem16);
    assign need = bytes_per_elem(mode);
    assign have = (level >= LVL_W'(need));

    swd_mask_feed #(.MASK_W(BYTE_W)) u_mask (
        .clk(clk), .rst(rst),
        .mask_valid(mask_valid), .mask_data(mask_data), .mask_ready(mask_ready),
        .take(fire), .bit_valid(bit_valid), .bit_val(bit_val)
    );

    swd_byte_align #(.LANES(LANES)) u_align (
        .clk(clk), .rst(rst),
        .in_valid(pk_valid), .in_data(pk_data), .in_ready(pk_ready),
        .pop(pop), .head0(head0), .head1(head1), .level(level)
    );

    swd_group_track #(.CNT_ELEM_W(CNT_ELEM_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst),
        .fire(fire), .bytes_used(2'(pop)), .group_elems(cfg_group_elems),
        .cnt_data(gcnt_data), .is_last(is_last), .err(err_count)
    );

    assign out_valid  = bit_valid && (!bit_val || have) && (!is_last || gcnt_valid);
    assign fire       = out_valid && out_ready;
    assign pop        = (fire && bit_val) ? POP_W'(need) : POP_W'(0);
    assign gcnt_ready = fire && is_last;

    assign elem.data = bit_val ? form_elem(mode, head0, head1) : '0;
    assign elem.last = is_last;
    assign out_data  = elem.data;
    assign out_last  = elem.last;

    // R6: a closing element is never offered without its count
    p_last_waits_cnt_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> gcnt_valid);

    // R9: a stalled element is held unchanged
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !out_last) |=> (out_valid && $stable(out_data)));

    // R2: a zero mask bit yields no packed byte consumption
    p_zero_no_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && !bit_val) |-> (pop == '0));

endmodule

// File: tb/tb_sparse_weight_decomp.sv
module tb_sparse_weight_decomp;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_elem16;
    logic [15:0] cfg_group_elems;
    logic        mask_valid;
    logic [7:0]  mask_data;
    logic        mask_ready;
    logic        pk_valid;
    logic [15:0] pk_data;
    logic        pk_ready;
    logic        gcnt_valid;
    logic [31:0] gcnt_data;
    logic        gcnt_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_last;
    logic        out_ready;
    logic        err_count;

    always #10 clk = ~clk;

    sparse_weight_decomp dut (
        .clk(clk), .rst(rst),
        .cfg_elem16(cfg_elem16), .cfg_group_elems(cfg_group_elems),
        .mask_valid(mask_valid), .mask_data(mask_data), .mask_ready(mask_ready),
        .pk_valid(pk_valid), .pk_data(pk_data), .pk_ready(pk_ready),
        .gcnt_valid(gcnt_valid), .gcnt_data(gcnt_data), .gcnt_ready(gcnt_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .err_count(err_count)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [15:0] ev [64];
    logic [7:0]  mq [16];
    logic [15:0] pq [64];
    logic [31:0] cq [16];
    int nm, np, nc;

    logic [15:0] got_d [64];
    logic        got_l [64];
    int          got_c [64];
    int          got_n;
    int          stall_bad;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        mask_valid = 0; pk_valid = 0; gcnt_valid = 0; out_ready = 0;
        mask_data = 0; pk_data = 0; gcnt_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Compress ev[0..n-1] into the three streams
    task automatic build(input bit wide, input int n, input int g);
        int nb;
        int gb;
        nb = 0; gb = 0; nc = 0;
        for (int i = 0; i < 16; i++) mq[i] = 8'h00;
        for (int i = 0; i < 64; i++) pq[i] = 16'h0000;
        for (int e = 0; e < n; e++) begin
            if (ev[e] != 16'h0000) begin
                mq[e/8][e%8] = 1'b1;
                pq[nb/2][8*(nb%2) +: 8] = ev[e][7:0];
                nb++; gb++;
                if (wide) begin
                    pq[nb/2][8*(nb%2) +: 8] = ev[e][15:8];
                    nb++; gb++;
                end
            end
            if ((e % g) == g - 1) begin
                cq[nc] = gb;
                nc++;
                gb = 0;
            end
        end
        nm = (n + 7) / 8;
        np = (nb + 1) / 2;
        cfg_elem16 = wide;
        cfg_group_elems = 16'(g);
    endtask

    task automatic feed_mask();
        int k = 0;
        while (k < nm) begin
            @(negedge clk);
            mask_valid = 1; mask_data = mq[k];
            #8;
            if (mask_ready) k++;
            @(posedge clk);
        end
        @(negedge clk);
        mask_valid = 0;
    endtask

    task automatic feed_pk();
        int k = 0;
        while (k < np) begin
            @(negedge clk);
            pk_valid = 1; pk_data = pq[k];
            #8;
            if (pk_ready) k++;
            @(posedge clk);
        end
        @(negedge clk);
        pk_valid = 0;
    endtask

    task automatic feed_cnt(input int delay);
        int k = 0;
        repeat (delay) @(posedge clk);
        while (k < nc) begin
            @(negedge clk);
            gcnt_valid = 1; gcnt_data = cq[k];
            #8;
            if (gcnt_ready) k++;
            @(posedge clk);
        end
        @(negedge clk);
        gcnt_valid = 0;
    endtask

    task automatic collect(input int n, input bit throttle);
        bit          prev_stall = 0;
        logic [15:0] prev_d = 0;
        got_n = 0; stall_bad = 0;
        while (got_n < n) begin
            @(negedge clk);
            out_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
            #8;
            if (prev_stall && (!out_valid || out_data != prev_d)) stall_bad++;
            prev_stall = out_valid && !out_ready && !out_last;
            prev_d = out_data;
            if (out_valid && out_ready) begin
                got_d[got_n] = out_data;
                got_l[got_n] = out_last;
                got_c[got_n] = cyc;
                got_n++;
            end
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 0;
    endtask

    task automatic run(input int n, input bit throttle, input int cdelay);
        fork
            feed_mask();
            feed_pk();
            feed_cnt(cdelay);
            collect(n, throttle);
        join
    endtask

    task automatic compare(input int n, input int g, input string tag);
        int bad_d = 0;
        int bad_l = 0;
        for (int e = 0; e < n; e++) begin
            if (got_d[e] != ev[e]) begin
                bad_d++;
                $display("FAIL %s data elem %0d actual=%0h expected=%0h", tag, e, got_d[e], ev[e]);
            end
            if (got_l[e] != ((e % g) == g - 1)) begin
                bad_l++;
                $display("FAIL R5 last elem %0d actual=%0b expected=%0b", e, got_l[e], (e % g) == g - 1);
            end
        end
        checks += 2;
        if (bad_d != 0) errors++;
        if (bad_l != 0) errors++;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        mask_valid = 0; pk_valid = 0; gcnt_valid = 0; out_ready = 0;
        mask_data = 0; pk_data = 0; gcnt_data = 0;
        cfg_elem16 = 1; cfg_group_elems = 16'd4;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
        chk(err_count == 0, "R1 err in reset", err_count, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(mask_ready == 1, "R1 mask_ready", mask_ready, 1);
        chk(pk_ready == 1, "R1 pk_ready", pk_ready, 1);
        chk(gcnt_ready == 0, "R1 gcnt_ready", gcnt_ready, 0);
    endtask

    // R2 R3 R10: 16-bit elements with zeros, two groups
    task automatic t_wide_basic();
        do_reset();
        for (int i = 0; i < 12; i++)
            ev[i] = ((i % 3) == 1) ? 16'h0000 : 16'(16'h1203 + i * 16'h0111);
        build(1, 12, 6);
        run(12, 0, 0);
        compare(12, 6, "R3_R10");
        chk(err_count == 0, "R7 no error on matching counts", err_count, 0);
    endtask

    // R4 R8: 8-bit sign extension, groups of 5 straddle mask bytes
    task automatic t_narrow();
        do_reset();
        for (int i = 0; i < 15; i++) begin
            logic [7:0] b;
            b = 8'(8'h80 + i * 37);
            ev[i] = ((i % 4) == 2 || b == 0) ? 16'h0000 : {{8{b[7]}}, b};
        end
        build(0, 15, 5);
        run(15, 0, 0);
        compare(15, 5, "R4_R8");
        chk(err_count == 0, "R8 counts match across mid-byte groups", err_count, 0);
    endtask

    // R9: back-pressure holds the offered element
    task automatic t_backpressure();
        do_reset();
        for (int i = 0; i < 12; i++)
            ev[i] = ((i % 5) == 0) ? 16'h0000 : 16'(16'hA001 + i * 16'h0203);
        build(1, 12, 4);
        run(12, 1, 0);
        compare(12, 4, "R9_stall");
        chk(stall_bad == 0, "R9 stalled element held", stall_bad, 0);
    endtask

    // R6: last element waits for the group count
    task automatic t_late_count();
        do_reset();
        for (int i = 0; i < 4; i++) ev[i] = 16'(16'h0011 + i);
        build(0, 4, 4);
        fork
            feed_mask();
            feed_pk();
            feed_cnt(25);
            collect(4, 0);
            begin
                repeat (18) @(posedge clk);
                @(negedge clk);
                #8;
                chk(got_n == 3, "R6 elements before count", got_n, 3);
                chk(out_valid == 0, "R6 last held back", out_valid, 0);
                chk(gcnt_ready == 0, "R6 no count taken early", gcnt_ready, 0);
            end
        join
        compare(4, 4, "R6");
    endtask

    // R7: wrong byte count sets a sticky error
    task automatic t_mismatch();
        do_reset();
        for (int i = 0; i < 8; i++) ev[i] = (i == 3) ? 16'h0000 : 16'(16'h3300 + i);
        build(1, 8, 4);
        cq[0] = cq[0] + 1;
        fork
            feed_mask();
            feed_pk();
            feed_cnt(0);
            collect(8, 0);
            begin
                while (got_n < 4) @(posedge clk);
                @(negedge clk);
                chk(err_count == 1, "R7 error after bad group", err_count, 1);
            end
        join
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(err_count == 1, "R7 error stays after good group", err_count, 1);
    endtask

    // R9: full rate with two-byte elements
    task automatic t_throughput();
        do_reset();
        for (int i = 0; i < 16; i++) ev[i] = 16'(16'h5A01 + i * 16'h0101);
        build(1, 16, 8);
        run(16, 0, 0);
        compare(16, 8, "R9_rate");
        chk(got_c[15] - got_c[0] == 15, "R9 one element per cycle", got_c[15] - got_c[0], 15);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_wide_basic();
        t_narrow();
        t_backpressure();
        t_late_count();
        t_mismatch();
        t_throughput();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule